// File: doc/BRIEF.md
# Byte-Lane Pipelined Dual-Port RAM

A synchronous memory with two fully independent ports, A and B, each with its own clock. Either port can read or write any word at any time, including the word the other port is using. A port captures its select pair, direction, lane enables, address and write data on a rising edge. The read or write itself is carried out on the following edge of the same port's clock. Read data leaves through an output register.

Each word is made of byte lanes, four 9-bit lanes by default. Every port access picks its lanes with active-low lane enables. A write changes only the picked lanes. A read marks only the picked lanes as valid. There are no tri-state pads. Each port instead has a data-out bus and one valid flag per lane. An active-low output enable gates both of them without waiting for a clock.

If both ports write the same word on the same edge, port B takes the lanes that both ports enabled. The default depth is 1024 words. Setting the address width to 14 gives the full 16384-word array.

Top module: `bl_dpram`

## Requirements
- R1: A port is selected only when its `cs_ni` is low and its `cs_i` is high. In any other cycle the port writes nothing, and its lane valid flags are 0 once that cycle's request reaches the output.
- R2: A selected request with `rd_wn_i` low writes only lane l (bits 9l to 9l+8) for each l whose `be_ni[l]` is low. Any mix of lanes is allowed. The other lanes of the word keep their contents.
- R3: For a selected request with `rd_wn_i` high, lane l is valid and carries the stored lane only if `be_ni[l]` was low. Lanes that are not valid read as zero on `rdata_o`.
- R4: A request captured on edge k takes effect on edge k+1. Its read data and valid flags appear after edge k+1 and are held until the next edge. A read captured on edge k+1 or later returns the data written by a request captured on edge k.
- R5: `oe_ni` acts without a clock. While it is high, every valid flag and every data bit of that port is 0. Once it is low again, the held read result shows again.
- R6: The two ports work independently, and each can reach every address. A word written through one port reads back through the other.
- R7: If both ports write the same address on the same effective edge, port B's data ends up in each lane that both ports enabled. In every other lane, the data comes from the port that enabled that lane.
- R8: A read that takes effect on the same edge as a write to the same address, from either port, returns the contents from before that write.
- R9: While `rst_ni` is low, and after it is released until a read completes, all valid flags and data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Port A clock |
| clk_b_i | input | 1 | Port B clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the port pipelines |
| a_cs_ni | input | 1 | Port A select, active low |
| a_cs_i | input | 1 | Port A select, active high |
| a_rd_wn_i | input | 1 | Port A direction: 1 = read, 0 = write |
| a_be_ni | input | LANES | Port A lane enables, active low |
| a_oe_ni | input | 1 | Port A output enable, active low, asynchronous |
| a_addr_i | input | ADDR_W | Port A word address |
| a_wdata_i | input | LANES*LANE_W | Port A write data |
| a_rdata_o | output | LANES*LANE_W | Port A read data; lanes that are not valid read as zero |
| a_vld_o | output | LANES | Port A per-lane read valid |
| b_cs_ni | input | 1 | Port B select, active low |
| b_cs_i | input | 1 | Port B select, active high |
| b_rd_wn_i | input | 1 | Port B direction: 1 = read, 0 = write |
| b_be_ni | input | LANES | Port B lane enables, active low |
| b_oe_ni | input | 1 | Port B output enable, active low, asynchronous |
| b_addr_i | input | ADDR_W | Port B word address |
| b_wdata_i | input | LANES*LANE_W | Port B write data |
| b_rdata_o | output | LANES*LANE_W | Port B read data; lanes that are not valid read as zero |
| b_vld_o | output | LANES | Port B per-lane read valid |

## Verification
Full-word writes and reads cover both ends of the address space, once from each port and once across ports. A failure here separates a broken data path from a broken lane decode. Single-lane, half-word and alternating lane masks on writes and on reads show whether masking is applied per lane or to the whole word. Collisions on one address on the same edge tell B-wins merging apart from last-writer or A-wins behaviour, and read-while-write cases tell old-data return apart from write-through. Toggling the output enable between clock edges, together with deselects of each polarity, checks the gate and the decoder on their own, and a long random mix over a small address set keeps the ports colliding.

// File: rtl/bl_dpram_pkg.sv
package bl_dpram_pkg;
  localparam int unsigned DEF_ADDR_W = 10;
  localparam int unsigned DEF_LANES  = 4;
  localparam int unsigned DEF_LANE_W = 9;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;
endpackage

// File: rtl/bl_dpram_bank.sv
// One storage bank, written by a single port; two asynchronous read taps.
module bl_dpram_bank #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                      clk_i,
  input  logic [LANES-1:0]          wr_i,
  input  logic [ADDR_W-1:0]         waddr_i,
  input  logic [LANES*LANE_W-1:0]   wdata_i,
  input  logic [ADDR_W-1:0]         raddr0_i,
  input  logic [ADDR_W-1:0]         raddr1_i,
  output logic [LANES*LANE_W-1:0]   rdata0_o,
  output logic [LANES*LANE_W-1:0]   rdata1_o
);
  localparam int unsigned DATA_W = LANES * LANE_W;
  localparam int unsigned DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    for (int l = 0; l < int'(LANES); l++) begin
      if (wr_i[l]) mem[waddr_i][l*LANE_W +: LANE_W] <= wdata_i[l*LANE_W +: LANE_W];
    end
  end

  assign rdata0_o = mem[raddr0_i];
  assign rdata1_o = mem[raddr1_i];
endmodule

// File: rtl/bl_dpram_port.sv
// Per-port request capture and output stage.
module bl_dpram_port
  import bl_dpram_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cs_ni,
  input  logic                      cs_i,
  input  logic                      rd_wn_i,
  input  logic [LANES-1:0]          be_ni,
  input  logic                      oe_ni,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [LANES*LANE_W-1:0]   wdata_i,
  input  logic [LANES*LANE_W-1:0]   rdata_i,
  output logic [ADDR_W-1:0]         req_addr_o,
  output logic [LANES-1:0]          req_wr_o,
  output logic [LANES*LANE_W-1:0]   req_wdata_o,
  output logic [LANES*LANE_W-1:0]   rdata_o,
  output logic [LANES-1:0]          vld_o
);
  localparam int unsigned DATA_W = LANES * LANE_W;

  acc_e              acc;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  wr_q, rd_q, rd_vld_q;
  logic [DATA_W-1:0] dout_q;

  always_comb begin
    acc = ACC_IDLE;
    if (!cs_ni && cs_i) acc = rd_wn_i ? ACC_READ : ACC_WRITE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      wr_q     <= '0;
      rd_q     <= '0;
      rd_vld_q <= '0;
      dout_q   <= '0;
    end else begin
      addr_q   <= addr_i;
      wdata_q  <= wdata_i;
      wr_q     <= (acc == ACC_WRITE) ? ~be_ni : '0;
      rd_q     <= (acc == ACC_READ)  ? ~be_ni : '0;
      rd_vld_q <= rd_q;
      if (|rd_q) dout_q <= rdata_i;
    end
  end

  assign req_addr_o  = addr_q;
  assign req_wr_o    = wr_q;
  assign req_wdata_o = wdata_q;

  // output enable gates lanes without a clock
  for (genvar l = 0; l < int'(LANES); l++) begin : g_lane
    assign vld_o[l] = rd_vld_q[l] & ~oe_ni;
    assign rdata_o[l*LANE_W +: LANE_W] = vld_o[l] ? dout_q[l*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/bl_dpram.sv
module bl_dpram
  import bl_dpram_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned LANE_W = DEF_LANE_W
) (
  input  logic                      clk_a_i,
  input  logic                      clk_b_i,
  input  logic                      rst_ni,
  input  logic                      a_cs_ni,
  input  logic                      a_cs_i,
  input  logic                      a_rd_wn_i,
  input  logic [LANES-1:0]          a_be_ni,
  input  logic                      a_oe_ni,
  input  logic [ADDR_W-1:0]         a_addr_i,
  input  logic [LANES*LANE_W-1:0]   a_wdata_i,
  output logic [LANES*LANE_W-1:0]   a_rdata_o,
  output logic [LANES-1:0]          a_vld_o,
  input  logic                      b_cs_ni,
  input  logic                      b_cs_i,
  input  logic                      b_rd_wn_i,
  input  logic [LANES-1:0]          b_be_ni,
  input  logic                      b_oe_ni,
  input  logic [ADDR_W-1:0]         b_addr_i,
  input  logic [LANES*LANE_W-1:0]   b_wdata_i,
  output logic [LANES*LANE_W-1:0]   b_rdata_o,
  output logic [LANES-1:0]          b_vld_o
);
  localparam int unsigned DATA_W = LANES * LANE_W;

  logic [ADDR_W-1:0] a_addr_q, b_addr_q;
  logic [LANES-1:0]  a_wr_q, b_wr_q, a_wr_eff;
  logic [DATA_W-1:0] a_wdata_q, b_wdata_q;
  logic [DATA_W-1:0] ba_at_a, ba_at_b, bb_at_a, bb_at_b;
  logic [DATA_W-1:0] a_word, b_word;

  bl_dpram_port #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_port_a (
    .clk_i(clk_a_i), .rst_ni(rst_ni), .cs_ni(a_cs_ni), .cs_i(a_cs_i),
    .rd_wn_i(a_rd_wn_i), .be_ni(a_be_ni), .oe_ni(a_oe_ni), .addr_i(a_addr_i),
    .wdata_i(a_wdata_i), .rdata_i(a_word), .req_addr_o(a_addr_q),
    .req_wr_o(a_wr_q), .req_wdata_o(a_wdata_q), .rdata_o(a_rdata_o), .vld_o(a_vld_o)
  );

  bl_dpram_port #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_port_b (
    .clk_i(clk_b_i), .rst_ni(rst_ni), .cs_ni(b_cs_ni), .cs_i(b_cs_i),
    .rd_wn_i(b_rd_wn_i), .be_ni(b_be_ni), .oe_ni(b_oe_ni), .addr_i(b_addr_i),
    .wdata_i(b_wdata_i), .rdata_i(b_word), .req_addr_o(b_addr_q),
    .req_wr_o(b_wr_q), .req_wdata_o(b_wdata_q), .rdata_o(b_rdata_o), .vld_o(b_vld_o)
  );

  // B wins on lanes both ports write to one address on the same edge
  always_comb begin
    a_wr_eff = a_wr_q;
    if (a_addr_q == b_addr_q) a_wr_eff = a_wr_q & ~b_wr_q;
  end

  // word = bank_a ^ bank_b; each bank has a single writer
  bl_dpram_bank #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_bank_a (
    .clk_i(clk_a_i), .wr_i(a_wr_eff), .waddr_i(a_addr_q),
    .wdata_i(a_wdata_q ^ bb_at_a), .raddr0_i(a_addr_q), .raddr1_i(b_addr_q),
    .rdata0_o(ba_at_a), .rdata1_o(ba_at_b)
  );

  bl_dpram_bank #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_bank_b (
    .clk_i(clk_b_i), .wr_i(b_wr_q), .waddr_i(b_addr_q),
    .wdata_i(b_wdata_q ^ ba_at_b), .raddr0_i(a_addr_q), .raddr1_i(b_addr_q),
    .rdata0_o(bb_at_a), .rdata1_o(bb_at_b)
  );

  assign a_word = ba_at_a ^ bb_at_a;
  assign b_word = ba_at_b ^ bb_at_b;
endmodule

// File: rtl/bl_dpram_chk.sv
module bl_dpram_chk #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input logic                    clk_a_i,
  input logic                    clk_b_i,
  input logic                    rst_ni,
  input logic                    a_cs_ni,
  input logic                    a_cs_i,
  input logic                    a_rd_wn_i,
  input logic [LANES-1:0]        a_be_ni,
  input logic                    a_oe_ni,
  input logic [LANES*LANE_W-1:0] a_rdata_o,
  input logic [LANES-1:0]        a_vld_o,
  input logic                    b_cs_ni,
  input logic                    b_cs_i,
  input logic                    b_rd_wn_i,
  input logic [LANES-1:0]        b_be_ni,
  input logic                    b_oe_ni,
  input logic [LANES*LANE_W-1:0] b_rdata_o,
  input logic [LANES-1:0]        b_vld_o
);
  AST_A_DESEL_QUIET: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (a_cs_ni || !a_cs_i) |=> ##1 (a_vld_o == '0)); // R1
  AST_B_DESEL_QUIET: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (b_cs_ni || !b_cs_i) |=> ##1 (b_vld_o == '0)); // R1
  AST_A_LANE_MASK: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (!a_cs_ni && a_cs_i && a_rd_wn_i) |=> ##1 ((a_vld_o & $past(a_be_ni, 2)) == '0)); // R3
  AST_B_LANE_MASK: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (!b_cs_ni && b_cs_i && b_rd_wn_i) |=> ##1 ((b_vld_o & $past(b_be_ni, 2)) == '0)); // R3
  AST_A_READ_LATENCY: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (!a_cs_ni && a_cs_i && a_rd_wn_i && a_be_ni == '0) |=> ##1 (a_oe_ni || a_vld_o == '1)); // R4
  AST_B_READ_LATENCY: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (!b_cs_ni && b_cs_i && b_rd_wn_i && b_be_ni == '0) |=> ##1 (b_oe_ni || b_vld_o == '1)); // R4
  AST_A_OE_GATE: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    a_oe_ni |-> (a_vld_o == '0 && a_rdata_o == '0)); // R5
  AST_B_OE_GATE: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    b_oe_ni |-> (b_vld_o == '0 && b_rdata_o == '0)); // R5
endmodule

bind bl_dpram bl_dpram_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk_a_i(clk_a_i), .clk_b_i(clk_b_i), .rst_ni(rst_ni),
  .a_cs_ni(a_cs_ni), .a_cs_i(a_cs_i), .a_rd_wn_i(a_rd_wn_i), .a_be_ni(a_be_ni),
  .a_oe_ni(a_oe_ni), .a_rdata_o(a_rdata_o), .a_vld_o(a_vld_o),
  .b_cs_ni(b_cs_ni), .b_cs_i(b_cs_i), .b_rd_wn_i(b_rd_wn_i), .b_be_ni(b_be_ni),
  .b_oe_ni(b_oe_ni), .b_rdata_o(b_rdata_o), .b_vld_o(b_vld_o)
);

// File: tb/bl_dpram_tb.sv
module bl_dpram_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 10;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef struct packed {
    logic              cs_n;
    logic              cs;
    logic              rd_wn;
    logic [LANES-1:0]  be_n;
    logic              oe_n;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wd;
  } req_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic              a_cs_ni = 1'b1, a_cs_i = 1'b1, a_rd_wn_i = 1'b1, a_oe_ni = 1'b0;
  logic [LANES-1:0]  a_be_ni = '1;
  logic [ADDR_W-1:0] a_addr_i = '0;
  logic [DATA_W-1:0] a_wdata_i = '0;
  logic [DATA_W-1:0] a_rdata_o;
  logic [LANES-1:0]  a_vld_o;
  logic              b_cs_ni = 1'b1, b_cs_i = 1'b1, b_rd_wn_i = 1'b1, b_oe_ni = 1'b0;
  logic [LANES-1:0]  b_be_ni = '1;
  logic [ADDR_W-1:0] b_addr_i = '0;
  logic [DATA_W-1:0] b_wdata_i = '0;
  logic [DATA_W-1:0] b_rdata_o;
  logic [LANES-1:0]  b_vld_o;

  bl_dpram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_dut (
    .clk_a_i(clk), .clk_b_i(clk), .rst_ni(rst_ni),
    .a_cs_ni(a_cs_ni), .a_cs_i(a_cs_i), .a_rd_wn_i(a_rd_wn_i), .a_be_ni(a_be_ni),
    .a_oe_ni(a_oe_ni), .a_addr_i(a_addr_i), .a_wdata_i(a_wdata_i),
    .a_rdata_o(a_rdata_o), .a_vld_o(a_vld_o),
    .b_cs_ni(b_cs_ni), .b_cs_i(b_cs_i), .b_rd_wn_i(b_rd_wn_i), .b_be_ni(b_be_ni),
    .b_oe_ni(b_oe_ni), .b_addr_i(b_addr_i), .b_wdata_i(b_wdata_i),
    .b_rdata_o(b_rdata_o), .b_vld_o(b_vld_o)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  string tag = "R9";

  logic [DATA_W-1:0] ref_mem   [DEPTH];
  logic [LANES-1:0]  ref_known [DEPTH];
  req_t pa0, pa1, pb0, pb1;
  logic [LANES-1:0] rdl_a, rdl_b;

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] rnd_d();
    logic [63:0] t;
    t = {$urandom(), $urandom()};
    return t[DATA_W-1:0];
  endfunction

  function automatic req_t rq_idle();
    req_t r;
    r = '0;
    r.cs_n = 1'b1; r.cs = 1'b1; r.rd_wn = 1'b1; r.be_n = '1;
    return r;
  endfunction

  function automatic req_t rq_rd(input logic [ADDR_W-1:0] ad, input logic [LANES-1:0] be_n);
    req_t r;
    r = rq_idle();
    r.cs_n = 1'b0; r.addr = ad; r.be_n = be_n;
    return r;
  endfunction

  function automatic req_t rq_wr(input logic [ADDR_W-1:0] ad, input logic [LANES-1:0] be_n,
                                 input logic [DATA_W-1:0] d);
    req_t r;
    r = rq_rd(ad, be_n);
    r.rd_wn = 1'b0; r.wd = d;
    return r;
  endfunction

  // expected outputs for one port from its request two steps back
  task automatic run_port(input req_t r, input logic oe_n, input logic [DATA_W-1:0] act_d,
                          input logic [LANES-1:0] act_v, output logic [LANES-1:0] rdl);
    logic sel;
    logic [LANES-1:0] ev;
    logic [DATA_W-1:0] ed;
    sel = !r.cs_n && r.cs;
    rdl = (sel && r.rd_wn) ? ~r.be_n : '0;
    ev = rdl & {LANES{~oe_n}};
    ed = '0;
    for (int l = 0; l < LANES; l++) begin
      if (ev[l]) ed[l*LANE_W +: LANE_W] = ref_known[r.addr][l] ? ref_mem[r.addr][l*LANE_W +: LANE_W]
                                                                : act_d[l*LANE_W +: LANE_W];
    end
    chk("valid", 64'(act_v), 64'(ev));
    chk("data", 64'(act_d), 64'(ed));
  endtask

  task automatic apply_wr(input req_t r);
    if (!r.cs_n && r.cs && !r.rd_wn) begin
      for (int l = 0; l < LANES; l++) begin
        if (!r.be_n[l]) begin
          ref_mem[r.addr][l*LANE_W +: LANE_W] = r.wd[l*LANE_W +: LANE_W];
          ref_known[r.addr][l] = 1'b1;
        end
      end
    end
  endtask

  task automatic step(input req_t na, input req_t nb);
    @(negedge clk);
    run_port(pa1, a_oe_ni, a_rdata_o, a_vld_o, rdl_a);
    run_port(pb1, b_oe_ni, b_rdata_o, b_vld_o, rdl_b);
    apply_wr(pa1);
    apply_wr(pb1); // B applied last: wins on shared lanes (R7)
    pa1 = pa0; pa0 = na;
    pb1 = pb0; pb0 = nb;
    a_cs_ni = na.cs_n; a_cs_i = na.cs; a_rd_wn_i = na.rd_wn; a_be_ni = na.be_n;
    a_oe_ni = na.oe_n; a_addr_i = na.addr; a_wdata_i = na.wd;
    b_cs_ni = nb.cs_n; b_cs_i = nb.cs; b_rd_wn_i = nb.rd_wn; b_be_ni = nb.be_n;
    b_oe_ni = nb.oe_n; b_addr_i = nb.addr; b_wdata_i = nb.wd;
    #1;
    // oe acts between edges (R5)
    chk("oe-gated valid A", 64'(a_vld_o), 64'(rdl_a & {LANES{~a_oe_ni}}));
    chk("oe-gated valid B", 64'(b_vld_o), 64'(rdl_b & {LANES{~b_oe_ni}}));
  endtask

  task automatic flush();
    step(rq_idle(), rq_idle());
    step(rq_idle(), rq_idle());
  endtask

  function automatic logic [ADDR_W-1:0] hot_addr(input int k);
    return (k < 8) ? ADDR_W'(k) : ADDR_W'(DEPTH - 16 + k);
  endfunction

  logic [LANES-1:0] masks [8] = '{4'b1110, 4'b1101, 4'b1011, 4'b0111,
                                  4'b1100, 4'b0011, 4'b1010, 4'b0101};

  initial begin
    req_t ra, rb;
    for (int i = 0; i < DEPTH; i++) begin
      ref_mem[i] = '0;
      ref_known[i] = '0;
    end
    pa0 = rq_idle(); pa1 = rq_idle(); pb0 = rq_idle(); pb1 = rq_idle();
    repeat (3) @(negedge clk);
    tag = "R9";
    chk("reset valid A", 64'(a_vld_o), 0);
    chk("reset data A", 64'(a_rdata_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("post-reset valid B", 64'(b_vld_o), 0);
    chk("post-reset data B", 64'(b_rdata_o), 0);

    tag = "R2";  // full-word fill at both address ends
    for (int i = 0; i < 8; i++) step(rq_wr(hot_addr(i), '0, rnd_d()), rq_wr(hot_addr(i+8), '0, rnd_d()));
    flush();

    tag = "R6";  // cross-port readback
    for (int i = 0; i < 8; i++) step(rq_rd(hot_addr(i+8), '0), rq_rd(hot_addr(i), '0));
    flush();

    tag = "R2";  // lane-masked writes, full readback
    for (int i = 0; i < 8; i++) step(rq_wr(hot_addr(i), masks[i], rnd_d()), rq_wr(hot_addr(i+8), masks[7-i], rnd_d()));
    for (int i = 0; i < 8; i++) step(rq_rd(hot_addr(i), '0), rq_rd(hot_addr(i+8), '0));
    flush();

    tag = "R3";  // lane-masked reads
    for (int i = 0; i < 8; i++) step(rq_rd(hot_addr(i), masks[i]), rq_rd(hot_addr(i+8), masks[(i+3)%8]));
    step(rq_rd(hot_addr(1), '1), rq_rd(hot_addr(9), '1));
    flush();

    tag = "R4";  // write then back-to-back read on the next request
    for (int i = 0; i < 4; i++) begin
      step(rq_wr(hot_addr(i), '0, rnd_d()), rq_idle());
      step(rq_idle(), rq_rd(hot_addr(i), '0));
    end
    for (int i = 0; i < 8; i++) step(rq_rd(hot_addr(i), '0), rq_rd(hot_addr(15-i), '0));
    flush();

    tag = "R1";  // deselects of each polarity
    ra = rq_wr(hot_addr(2), '0, rnd_d()); ra.cs_n = 1'b1;
    rb = rq_wr(hot_addr(3), '0, rnd_d()); rb.cs = 1'b0;
    step(ra, rb);
    ra = rq_rd(hot_addr(2), '0); ra.cs = 1'b0;
    rb = rq_rd(hot_addr(3), '0); rb.cs_n = 1'b1; rb.cs = 1'b0;
    step(ra, rb);
    step(rq_rd(hot_addr(2), '0), rq_rd(hot_addr(3), '0));
    flush();

    tag = "R7";  // same-edge collisions
    for (int j = 0; j < 8; j++) begin
      step(rq_wr(hot_addr(4), masks[(j+2)%8], rnd_d()), rq_wr(hot_addr(4), masks[j], rnd_d()));
      step(rq_rd(hot_addr(4), '0), rq_idle());
    end
    step(rq_wr(hot_addr(5), '0, rnd_d()), rq_wr(hot_addr(5), '0, rnd_d()));
    step(rq_idle(), rq_rd(hot_addr(5), '0));
    flush();

    tag = "R8";  // read during write to the same word
    step(rq_rd(hot_addr(6), '0), rq_wr(hot_addr(6), '0, rnd_d()));
    step(rq_rd(hot_addr(6), '0), rq_idle());
    step(rq_wr(hot_addr(7), 4'b0110, rnd_d()), rq_rd(hot_addr(7), '0));
    step(rq_idle(), rq_rd(hot_addr(7), '0));
    flush();

    tag = "R5";  // output enable toggled between edges
    for (int i = 0; i < 6; i++) begin
      ra = rq_rd(hot_addr(i), '0); ra.oe_n = i[0];
      rb = rq_rd(hot_addr(i+8), 4'b0101); rb.oe_n = ~i[0];
      step(ra, rb);
    end
    ra = rq_idle(); ra.oe_n = 1'b1;
    step(ra, rq_idle());
    step(rq_idle(), rq_idle());
    flush();

    tag = "R6";  // random mix with frequent collisions
    for (int n = 0; n < 400; n++) begin
      for (int p = 0; p < 2; p++) begin
        int op;
        req_t r;
        op = $urandom_range(0, 9);
        if (op < 4)      r = rq_rd(hot_addr($urandom_range(0, 15)), LANES'($urandom));
        else if (op < 8) r = rq_wr(hot_addr($urandom_range(0, 15)), LANES'($urandom), rnd_d());
        else             r = rq_idle();
        r.oe_n = ($urandom_range(0, 7) == 0);
        if (p == 0) ra = r; else rb = r;
      end
      step(ra, rb);
    end
    flush();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R6 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule